// File: doc/BRIEF.md
# Dithered Dual-Modulus Toggle Divider

This block turns a fast reference clock into a square wave whose mean frequency sits between two neighbouring integer divisions of that clock. A counter climbs from zero to an active modulus and then returns to zero. Each return (a "wrap") ends one half period of the output and flips the output level. At every wrap a dither sequencer chooses which of two programmable moduli, A or B, governs the next half period. Mixing the two in a controlled proportion gives a fractional average division.

Two selection policies are offered. In threshold mode the policy uses a 0..999 dither index: every index at or below an adjust value gets modulus A, and the rest get modulus B. In interleaved mode a fixed eight-step A/B pattern spreads the B half periods evenly, so the edges never drift far from an ideal grid. A second 0..999 index produces a one-bit trim select. This bit is meant for an external oscillator-pull control, which is outside this block. A slow heartbeat output flips once per configurable number of full dither cycles. Left at its default, that is once per second at the nominal 81 kHz output.

The output level is a two-state machine with states LVL_LOW and LVL_HIGH. Its only transitions are LVL_LOW to LVL_HIGH on a wrap and LVL_HIGH to LVL_LOW on a wrap. With no wrap, each state holds.

Top module: `dither_toggle_div`

## Requirements
- R1: The counter runs 0..M, where M is the modulus in force, so every half period lasts M+1 clock cycles. `sq_o` flips at the clock edge that ends the cycle in which the counter equals M, and at no other edge.
- R2: The first half period after reset uses the parameter DEF_MOD_A (default 369) and so lasts DEF_MOD_A+1 cycles. The trim select comes out of reset as the result of 0 < DEF_TRIM_ADJ (default 500), which is high.
- R3: Half periods are numbered 0, 1, 2, … from reset. Half period n carries the dither index n mod DITHER_SPAN (default 1000). With `mode_i` = 0 (threshold), half period n uses `mod_a_i` when its index is <= `dither_adj_i` and uses `mod_b_i` otherwise.
- R4: With `mode_i` = 1 (interleaved), half period n uses `mod_b_i` when (index mod 8) is 1, 4 or 7, and uses `mod_a_i` for 0, 2, 3, 5 and 6.
- R5: `mode_i`, `mod_a_i`, `mod_b_i`, `dither_adj_i` and `trim_adj_i` are taken only at a wrap, and they apply to the half period that starts there. A change in the middle of a half period leaves that half period's length unchanged.
- R6: In threshold mode with a fixed adjust value j < DITHER_SPAN, any DITHER_SPAN consecutive half periods total (j+1)(A+1) + (DITHER_SPAN-1-j)(B+1) cycles. With j = DITHER_SPAN-1, every half period uses A.
- R7: A trim index counts 0..DITHER_SPAN-1, one step per wrap. During half period n, `trim_fast_o` is high exactly when the trim index is strictly less than the `trim_adj_i` value taken at that half period's start. A value of 0 keeps it low, and any value >= DITHER_SPAN keeps it high.
- R8: `beat_o` flips at the wrap that ends half period k·HB_LIMIT·DITHER_SPAN − 1, for every k >= 1, and at no other time (HB_LIMIT default 162).
- R9: While `rst_ni` is low at a rising clock edge, the block clears its counters, `sq_o` and `beat_o`, and reloads the reset defaults (synchronous, active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 0 = threshold dither, 1 = interleaved eight-step pattern |
| mod_a_i | input | MOD_W | Modulus A (half period = value + 1 cycles) |
| mod_b_i | input | MOD_W | Modulus B |
| dither_adj_i | input | clog2(DITHER_SPAN) | Threshold-mode switch point |
| trim_adj_i | input | clog2(DITHER_SPAN) | Trim select switch point |
| sq_o | output | 1 | Dithered square wave |
| trim_fast_o | output | 1 | Oscillator trim select, high = fast setting |
| beat_o | output | 1 | Heartbeat toggle |

## Verification
The assertions assume that `rst_ni` is low at the first rising edge, so that every register starts from a defined value. They also assume the configuration inputs never carry X or Z when a wrap takes them in. They make no assumption about how those inputs move between wraps, because the design has to ignore such movement anyway. The stimulus changes inputs only on falling edges and holds reset over several edges. It keeps both moduli small, so that full thousand-wrap windows and two heartbeat flips fit in the run. It deliberately changes the moduli part-way through a half period.

// File: rtl/dtd_pkg.sv
package dtd_pkg;

    // Output level of the half-period engine
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_e;

    // Dither selection policy
    typedef enum logic {
        DMODE_THRESH  = 1'b0,
        DMODE_PATTERN = 1'b1
    } dmode_e;

    // Bit s set means slot s of the eight-step pattern takes modulus B
    localparam logic [7:0] PATTERN_B_SLOTS = 8'b1001_0010;

    function automatic logic pattern_wants_b(input logic [2:0] slot);
        return PATTERN_B_SLOTS[slot];
    endfunction

endpackage

// File: rtl/dtd_halfperiod.sv
module dtd_halfperiod
    import dtd_pkg::*;
#(
    parameter int MOD_W   = 12,
    parameter int RST_MOD = 369
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [MOD_W-1:0] mod_next_i,
    output logic             wrap_o,
    output logic             sq_o,
    output logic [MOD_W-1:0] cnt_o,
    output logic [MOD_W-1:0] cur_mod_o
);

    localparam logic [MOD_W-1:0] MOD_RST = MOD_W'(RST_MOD);

    level_e           lvl_q;
    level_e           lvl_d;
    logic [MOD_W-1:0] cnt_q;
    logic [MOD_W-1:0] mod_q;

    assign wrap_o = (cnt_q == mod_q);

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lvl_q <= LVL_LOW;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    // Next-state logic: every wrap ends a half period
    always_comb begin
        lvl_d = lvl_q;
        unique case (lvl_q)
            LVL_LOW:  if (wrap_o) lvl_d = LVL_HIGH;
            LVL_HIGH: if (wrap_o) lvl_d = LVL_LOW;
            default:  lvl_d = LVL_LOW;
        endcase
    end

    // Counter and modulus held for the running half period
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            mod_q <= MOD_RST;
        end else if (wrap_o) begin
            cnt_q <= '0;
            mod_q <= mod_next_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output decode
    always_comb begin
        unique case (lvl_q)
            LVL_LOW:  sq_o = 1'b0;
            LVL_HIGH: sq_o = 1'b1;
            default:  sq_o = 1'b0;
        endcase
    end

    assign cnt_o     = cnt_q;
    assign cur_mod_o = mod_q;

endmodule

// File: rtl/dtd_sequencer.sv
module dtd_sequencer
    import dtd_pkg::*;
#(
    parameter int MOD_W = 12,
    parameter int IDX_W = 10,
    parameter int SPAN  = 1000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wrap_i,
    input  logic             mode_i,
    input  logic [MOD_W-1:0] mod_a_i,
    input  logic [MOD_W-1:0] mod_b_i,
    input  logic [IDX_W-1:0] adj_i,
    output logic [MOD_W-1:0] mod_next_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             span_end_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SPAN - 1);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_inc;
    logic             pick_b;

    // Index of the half period that the coming wrap opens
    always_comb begin
        if (idx_q == IDX_LAST) begin
            idx_inc = '0;
        end else begin
            idx_inc = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            idx_q <= '0;
        end else if (wrap_i) begin
            idx_q <= idx_inc;
        end
    end

    // Modulus policy for the coming half period
    always_comb begin
        unique case (dmode_e'(mode_i))
            DMODE_THRESH:  pick_b = (idx_inc > adj_i);
            DMODE_PATTERN: pick_b = pattern_wants_b(idx_inc[2:0]);
            default:       pick_b = 1'b0;
        endcase
    end

    assign mod_next_o = pick_b ? mod_b_i : mod_a_i;
    assign idx_o      = idx_q;
    assign span_end_o = wrap_i && (idx_q == IDX_LAST);

endmodule

// File: rtl/dtd_trim.sv
module dtd_trim #(
    parameter int IDX_W    = 10,
    parameter int SPAN     = 1000,
    parameter int DEF_TRIM = 500
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wrap_i,
    input  logic [IDX_W-1:0] adj_i,
    output logic             trim_o
);

    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(SPAN - 1);
    localparam logic             TRIM_RST  = (DEF_TRIM > 0);

    logic [IDX_W-1:0] t_q;
    logic [IDX_W-1:0] t_inc;
    logic             trim_q;

    always_comb begin
        if (t_q == IDX_LAST) begin
            t_inc = '0;
        end else begin
            t_inc = t_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            t_q    <= '0;
            trim_q <= TRIM_RST;
        end else if (wrap_i) begin
            t_q    <= t_inc;
            trim_q <= (t_inc < adj_i);
        end
    end

    assign trim_o = trim_q;

endmodule

// File: rtl/dtd_heartbeat.sv
module dtd_heartbeat #(
    parameter int HB_LIMIT = 162,
    parameter int CNT_W    = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             span_end_i,
    output logic             beat_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HB_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             beat_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            beat_q <= 1'b0;
        end else if (span_end_i) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q  <= '0;
                beat_q <= ~beat_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign beat_o = beat_q;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/dither_toggle_div.sv
module dither_toggle_div #(
    parameter int MOD_W        = 12,
    parameter int DITHER_SPAN  = 1000,
    parameter int HB_LIMIT     = 162,
    parameter int DEF_MOD_A    = 369,
    parameter int DEF_TRIM_ADJ = 500
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           mode_i,
    input  logic [MOD_W-1:0]               mod_a_i,
    input  logic [MOD_W-1:0]               mod_b_i,
    input  logic [$clog2(DITHER_SPAN)-1:0] dither_adj_i,
    input  logic [$clog2(DITHER_SPAN)-1:0] trim_adj_i,
    output logic                           sq_o,
    output logic                           trim_fast_o,
    output logic                           beat_o
);

    localparam int IDX_W = $clog2(DITHER_SPAN);
    localparam int HB_W  = $clog2(HB_LIMIT + 1);

    logic             wrap_w;
    logic             span_end_w;
    logic [MOD_W-1:0] mod_next_w;
    logic [MOD_W-1:0] cnt_w;
    logic [MOD_W-1:0] cur_mod_w;
    logic [IDX_W-1:0] idx_w;
    logic [HB_W-1:0]  hb_cnt_w;

    dtd_halfperiod #(
        .MOD_W  (MOD_W),
        .RST_MOD(DEF_MOD_A)
    ) u_half (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mod_next_i(mod_next_w),
        .wrap_o    (wrap_w),
        .sq_o      (sq_o),
        .cnt_o     (cnt_w),
        .cur_mod_o (cur_mod_w)
    );

    dtd_sequencer #(
        .MOD_W(MOD_W),
        .IDX_W(IDX_W),
        .SPAN (DITHER_SPAN)
    ) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wrap_i    (wrap_w),
        .mode_i    (mode_i),
        .mod_a_i   (mod_a_i),
        .mod_b_i   (mod_b_i),
        .adj_i     (dither_adj_i),
        .mod_next_o(mod_next_w),
        .idx_o     (idx_w),
        .span_end_o(span_end_w)
    );

    dtd_trim #(
        .IDX_W   (IDX_W),
        .SPAN    (DITHER_SPAN),
        .DEF_TRIM(DEF_TRIM_ADJ)
    ) u_trim (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .wrap_i(wrap_w),
        .adj_i (trim_adj_i),
        .trim_o(trim_fast_o)
    );

    dtd_heartbeat #(
        .HB_LIMIT(HB_LIMIT),
        .CNT_W   (HB_W)
    ) u_beat (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .span_end_i(span_end_w),
        .beat_o    (beat_o),
        .cnt_o     (hb_cnt_w)
    );

endmodule

// File: rtl/dtd_checker.sv
module dtd_checker #(
    parameter int MOD_W    = 12,
    parameter int IDX_W    = 10,
    parameter int HB_W     = 8,
    parameter int SPAN     = 1000,
    parameter int HB_LIMIT = 162
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wrap_i,
    input logic             sq_i,
    input logic             trim_i,
    input logic             beat_i,
    input logic [MOD_W-1:0] cnt_i,
    input logic [MOD_W-1:0] mod_i,
    input logic [IDX_W-1:0] idx_i,
    input logic [HB_W-1:0]  hb_cnt_i
);

    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(SPAN);
    localparam logic [HB_W-1:0]  HB_END  = HB_W'(HB_LIMIT);

    AST_CNT_WITHIN_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_i <= mod_i); // R1
    AST_SQ_FLIPS_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_i |=> (sq_i != $past(sq_i))); // R1
    AST_SQ_HOLDS_MIDHALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(sq_i)); // R1
    AST_MOD_HELD_MIDHALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(mod_i)); // R5
    AST_IDX_IN_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idx_i < IDX_END); // R3
    AST_IDX_STEPS_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(idx_i)); // R3
    AST_TRIM_HELD_MIDHALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(trim_i)); // R7
    AST_BEAT_HELD_MIDHALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(beat_i)); // R8
    AST_BEAT_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hb_cnt_i < HB_END); // R8

endmodule

bind dither_toggle_div dtd_checker #(
    .MOD_W   (MOD_W),
    .IDX_W   (IDX_W),
    .HB_W    (HB_W),
    .SPAN    (DITHER_SPAN),
    .HB_LIMIT(HB_LIMIT)
) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wrap_i  (wrap_w),
    .sq_i    (sq_o),
    .trim_i  (trim_fast_o),
    .beat_i  (beat_o),
    .cnt_i   (cnt_w),
    .mod_i   (cur_mod_w),
    .idx_i   (idx_w),
    .hb_cnt_i(hb_cnt_w)
);

// File: tb/dither_toggle_div_tb_top.sv
module dither_toggle_div_tb_top;

    localparam int SPAN  = 1000;
    localparam int HB    = 2;
    localparam int DEF_A = 369;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_r = 1'b0;
    logic [11:0] moda_r = 12'd4;
    logic [11:0] modb_r = 12'd5;
    logic [9:0] dadj_r = 10'd629;
    logic [9:0] tadj_r = 10'd500;
    logic       sq, trim, beat;

    always #2.5 clk = ~clk;

    dither_toggle_div #(
        .MOD_W(12), .DITHER_SPAN(SPAN), .HB_LIMIT(HB),
        .DEF_MOD_A(DEF_A), .DEF_TRIM_ADJ(500)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_r),
        .mod_a_i(moda_r), .mod_b_i(modb_r),
        .dither_adj_i(dadj_r), .trim_adj_i(tadj_r),
        .sq_o(sq), .trim_fast_o(trim), .beat_o(beat)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit pat_b(input int idx);
        int s = idx % 8;
        return (s == 1) || (s == 4) || (s == 7);
    endfunction

    // Behavioural reference: remaining cycles of the running half period
    int m_rem, m_d, m_t, m_hbc;
    bit m_sq, m_hb, m_trim, m_useb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem = DEF_A + 1; m_d = 0; m_t = 0; m_hbc = 0;
            m_sq = 0; m_hb = 0; m_trim = 1;
        end else begin
            m_rem--;
            if (m_rem == 0) begin
                m_sq = !m_sq;
                m_d  = (m_d + 1) % SPAN;
                m_t  = (m_t + 1) % SPAN;
                if (m_d == 0) begin
                    m_hbc++;
                    if (m_hbc == HB) begin m_hbc = 0; m_hb = !m_hb; end
                end
                m_trim = (m_t < int'(tadj_r));
                m_useb = mode_r ? pat_b(m_d) : (m_d > int'(dadj_r));
                m_rem  = (m_useb ? int'(modb_r) : int'(moda_r)) + 1;
            end
        end
    end

    // Every-cycle comparison and half-period measurement
    int lens[$];
    int hb_at[$];
    int n_halves = 0;
    int run = 1;
    bit prev_sq = 0, prev_hb = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            run = 1; prev_sq = 0; prev_hb = 0;
        end else begin
            chk(sq == m_sq, "R1", "sq_o vs model", sq, m_sq);
            chk(trim == m_trim, "R7", "trim_fast_o vs model", trim, m_trim);
            chk(beat == m_hb, "R8", "beat_o vs model", beat, m_hb);
            if (sq != prev_sq) begin
                lens.push_back(run);
                n_halves++;
                run = 1;
            end else begin
                run++;
            end
            if (beat != prev_hb) hb_at.push_back(n_halves);
            prev_sq = sq; prev_hb = beat;
        end
    end

    function automatic int sum_lens(input int first, input int count);
        int s = 0;
        for (int i = first; i < first + count; i++) s += lens[i];
        return s;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int h;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(sq == 0, "R9", "sq_o in reset", sq, 0);
        chk(beat == 0, "R9", "beat_o in reset", beat, 0);
        chk(trim == 1, "R2", "trim_fast_o reset default", trim, 1);
        #1 rst_n = 1'b1;

        // Threshold window over indices 1..999,0
        wait (n_halves >= 1002);
        chk(lens[0] == DEF_A + 1, "R2", "first half length", lens[0], DEF_A + 1);
        chk(lens[629] == 5, "R3", "index 629 uses A", lens[629], 5);
        chk(lens[630] == 6, "R3", "index 630 uses B", lens[630], 6);
        chk(lens[1000] == 5, "R3", "index 0 uses A", lens[1000], 5);
        chk(sum_lens(1, 1000) == 5370, "R6", "1000-half total adj 629",
            sum_lens(1, 1000), 5370);

        // Interleaved pattern
        @(negedge clk);
        mode_r = 1'b1;
        h = n_halves + 1;
        wait (n_halves >= h + 17);
        for (int n = h; n < h + 16; n++) begin
            chk(lens[n] == (pat_b(n % SPAN) ? 6 : 5), "R4", "pattern half length",
                lens[n], pat_b(n % SPAN) ? 6 : 5);
        end

        // Mid-half modulus change is deferred to the next wrap
        h = n_halves;
        wait (n_halves > h);
        @(negedge clk);
        h = n_halves;
        moda_r = 12'd9; modb_r = 12'd9;
        wait (n_halves >= h + 2);
        chk(lens[h] == (pat_b(h % SPAN) ? 6 : 5), "R5", "running half unchanged",
            lens[h], pat_b(h % SPAN) ? 6 : 5);
        chk(lens[h + 1] == 10, "R5", "next half takes new modulus", lens[h + 1], 10);
        @(negedge clk);
        moda_r = 12'd4; modb_r = 12'd5;

        // Trim extremes
        tadj_r = 10'd0;
        h = n_halves;
        wait (n_halves >= h + 2);
        repeat (8) begin
            @(negedge clk);
            chk(trim == 0, "R7", "trim adj 0 keeps low", trim, 0);
        end
        tadj_r = 10'd1000;
        h = n_halves;
        wait (n_halves >= h + 2);
        repeat (8) begin
            @(negedge clk);
            chk(trim == 1, "R7", "trim adj 1000 keeps high", trim, 1);
        end
        tadj_r = 10'd500;

        // Threshold boundaries
        mode_r = 1'b0; dadj_r = 10'd999;
        h = n_halves + 1;
        wait (n_halves >= h + 1000);
        chk(sum_lens(h, 1000) == 5000, "R6", "adj 999 all A", sum_lens(h, 1000), 5000);
        @(negedge clk);
        dadj_r = 10'd0;
        h = n_halves + 1;
        wait (n_halves >= h + 1000);
        chk(sum_lens(h, 1000) == 5999, "R6", "adj 0 total", sum_lens(h, 1000), 5999);

        // Heartbeat flips
        wait (n_halves >= 4001);
        chk(hb_at.size() >= 2, "R8", "heartbeat flip count", hb_at.size(), 2);
        if (hb_at.size() >= 2) begin
            chk(hb_at[0] == 2000, "R8", "first heartbeat flip", hb_at[0], 2000);
            chk(hb_at[1] == 4000, "R8", "second heartbeat flip", hb_at[1], 4000);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule